// File: doc/BRIEF.md
# Two-Level Interrupt Status Controller

This block merges network-controller event sources into one interrupt line through two register levels. At the lower level, eight single-cycle event pulses set bits of a cause byte. A mask byte of the same layout selects which of those bits count. The lower level reports one pending signal: the OR over the cause bits whose mask bit is set.

At the upper level, a command-space status byte carries that pending signal as a live bit. It also holds three latched events: a device reset, a challenge being issued, and a challenge result becoming available. A command-space mask byte decides which status bits may raise the external interrupt.

Host software reaches both levels through a single byte-wide register port. A space-select input chooses the level. Latched bits are cleared by writing ones. Because the pending bit is re-derived from the cause and mask every cycle, a new event that arrives while the host is clearing earlier ones keeps the interrupt asserted.

Top module: `irq_hier_ctrl`

## Requirements
- R1: After reset, the cause byte, the cause mask, the status byte, the top mask and `irq_o` all read as zero.
- R2: An event pulse on `nic_evt_i[k]` sets cause bit k. Bit 0 is fragment counter, 1 receive, 2 transmit, 3 receive error, 4 transmit error, 5 FIFO error, 6 bus error and 7 receive buffer full. The bit stays set until it is cleared.
- R3: Writing the cause byte (lower space, address 0x09) clears each bit written as 1 and leaves each bit written as 0 unchanged.
- R4: The cause mask (lower space, address 0x08) is an 8-bit read/write register with the same bit layout as the cause byte. A 1 enables that cause.
- R5: Status bit 7 reads 1 exactly when at least one cause bit and its mask bit are both set. Writing 1 to status bit 7 has no effect.
- R6: A pulse on `cmd_evt_i[0]`, `[1]` or `[2]` sets status bit 6 (reset), bit 4 (challenge issued) or bit 3 (challenge result) respectively. Writing 1 to that status bit (command space, address 0x03) clears it. Status bits 5, 2, 1 and 0 always read 0.
- R7: The top mask (command space, address 0x02) is an 8-bit read/write register. The value 0x00 masks every source, and 0xF8 enables status bits 7 to 3.
- R8: `irq_o` equals, one clock later, the OR over bits 7 to 3 of (status AND top mask).
- R9: When an event pulse and a write-one-to-clear hit the same bit in the same cycle, at either level, the bit ends up set.
- R10: Reads of any other address, in either space, return 0. Writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| nic_evt_i | input | 8 | Lower-level event pulses, one per cause bit |
| cmd_evt_i | input | 3 | Upper-level event pulses: reset, challenge issued, challenge result |
| reg_cmd_i | input | 1 | Space select: 1 = command space, 0 = lower space |
| reg_we_i | input | 1 | Write strobe for the addressed register |
| reg_addr_i | input | 8 | Register address within the selected space |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data for the addressed register (combinational) |
| irq_o | output | 1 | Registered external interrupt line |

## Verification
The assertions assume that event inputs are single-cycle pulses sampled at the rising edge and that `reg_we_i` together with the address and data are stable around that edge. They also assume that reset is applied before any event occurs. The stimulus changes every input only on the falling clock edge and holds each write or pulse for exactly one cycle. Same-cycle collisions of an event and a clear are produced deliberately, so the event-priority property is exercised under those assumptions and not outside them.

// File: rtl/irq_hier_pkg.sv
package irq_hier_pkg;
    localparam int BYTE_W = 8;
    localparam int NCMD_SRC = 3;

    localparam logic [BYTE_W-1:0] ADR_NIC_MASK  = 8'h08;
    localparam logic [BYTE_W-1:0] ADR_NIC_CAUSE = 8'h09;
    localparam logic [BYTE_W-1:0] ADR_TOP_MASK  = 8'h02;
    localparam logic [BYTE_W-1:0] ADR_TOP_STAT  = 8'h03;

    localparam int POS_PEND  = 7;
    localparam int POS_RESET = 6;
    localparam int POS_CHAL  = 4;
    localparam int POS_CHRES = 3;

    localparam logic [BYTE_W-1:0] LIVE_BITS = 8'hF8;
endpackage

// File: rtl/nic_cause_bank.sv
module nic_cause_bank #(
    parameter int W = irq_hier_pkg::BYTE_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] evt_i,
    input  logic [W-1:0] clr_i,
    input  logic         mask_we_i,
    input  logic [W-1:0] mask_wdata_i,
    output logic [W-1:0] cause_o,
    output logic [W-1:0] mask_o,
    output logic         pend_o
);
    typedef struct packed {
        logic [W-1:0] cause;
        logic [W-1:0] mask;
    } bank_st_t;

    bank_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.cause = (st_q.cause & ~clr_i) | evt_i;
        if (mask_we_i) begin
            st_d.mask = mask_wdata_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cause_o = st_q.cause;
    assign mask_o  = st_q.mask;
    assign pend_o  = |(st_q.cause & st_q.mask);

    // R9
    evt_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_i != '0) |=> ((st_q.cause & $past(evt_i)) == $past(evt_i)));

    // R3
    clr_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i != '0) |=> ((st_q.cause & $past(clr_i & ~evt_i)) == '0));

    // R2
    cause_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_i == '0 && clr_i == '0) |=> $stable(st_q.cause));
endmodule

// File: rtl/top_status_bank.sv
module top_status_bank #(
    parameter int W    = irq_hier_pkg::BYTE_W,
    parameter int NSRC = irq_hier_pkg::NCMD_SRC,
    parameter int PEND_POS = irq_hier_pkg::POS_PEND,
    parameter int unsigned SRC_POS [NSRC] = '{irq_hier_pkg::POS_RESET,
                                              irq_hier_pkg::POS_CHAL,
                                              irq_hier_pkg::POS_CHRES},
    parameter logic [W-1:0] LIVE = irq_hier_pkg::LIVE_BITS
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            pend_i,
    input  logic [NSRC-1:0] sevt_i,
    input  logic [W-1:0]    clr_i,
    input  logic            tmask_we_i,
    input  logic [W-1:0]    tmask_wdata_i,
    output logic [W-1:0]    status_o,
    output logic [W-1:0]    tmask_o,
    output logic            irq_o
);
    typedef struct packed {
        logic [NSRC-1:0] lat;
        logic [W-1:0]    tmask;
        logic            irq;
    } top_st_t;

    top_st_t st_d, st_q;
    logic [W-1:0] status_w;

    always_comb begin
        status_w = '0;
        status_w[PEND_POS] = pend_i;
        for (int i = 0; i < NSRC; i++) begin
            status_w[SRC_POS[i]] = st_q.lat[i];
        end
    end

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < NSRC; i++) begin
            st_d.lat[i] = (st_q.lat[i] & ~clr_i[SRC_POS[i]]) | sevt_i[i];
        end
        if (tmask_we_i) begin
            st_d.tmask = tmask_wdata_i;
        end
        st_d.irq = |(status_w & st_q.tmask & LIVE);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign status_o = status_w;
    assign tmask_o  = st_q.tmask;
    assign irq_o    = st_q.irq;

    // R6
    lat_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sevt_i != '0) |=> ((st_q.lat & $past(sevt_i)) == $past(sevt_i)));
endmodule

// File: rtl/irq_hier_ctrl.sv
module irq_hier_ctrl
    import irq_hier_pkg::*;
#(
    parameter int W    = BYTE_W,
    parameter int NSRC = NCMD_SRC
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [W-1:0]    nic_evt_i,
    input  logic [NSRC-1:0] cmd_evt_i,
    input  logic            reg_cmd_i,
    input  logic            reg_we_i,
    input  logic [W-1:0]    reg_addr_i,
    input  logic [W-1:0]    reg_wdata_i,
    output logic [W-1:0]    reg_rdata_o,
    output logic            irq_o
);
    logic         hit_ncause, hit_nmask, hit_tstat, hit_tmask;
    logic [W-1:0] nic_clr, top_clr;
    logic [W-1:0] cause_w, nmask_w, status_w, tmask_w;
    logic         pend_w;

    assign hit_ncause = !reg_cmd_i && (reg_addr_i == ADR_NIC_CAUSE);
    assign hit_nmask  = !reg_cmd_i && (reg_addr_i == ADR_NIC_MASK);
    assign hit_tstat  =  reg_cmd_i && (reg_addr_i == ADR_TOP_STAT);
    assign hit_tmask  =  reg_cmd_i && (reg_addr_i == ADR_TOP_MASK);

    assign nic_clr = (reg_we_i && hit_ncause) ? reg_wdata_i : '0;
    assign top_clr = (reg_we_i && hit_tstat)  ? reg_wdata_i : '0;

    nic_cause_bank #(.W(W)) u_nic (
        .clk          (clk),
        .rst_n        (rst_n),
        .evt_i        (nic_evt_i),
        .clr_i        (nic_clr),
        .mask_we_i    (reg_we_i && hit_nmask),
        .mask_wdata_i (reg_wdata_i),
        .cause_o      (cause_w),
        .mask_o       (nmask_w),
        .pend_o       (pend_w)
    );

    top_status_bank #(.W(W), .NSRC(NSRC)) u_top (
        .clk           (clk),
        .rst_n         (rst_n),
        .pend_i        (pend_w),
        .sevt_i        (cmd_evt_i),
        .clr_i         (top_clr),
        .tmask_we_i    (reg_we_i && hit_tmask),
        .tmask_wdata_i (reg_wdata_i),
        .status_o      (status_w),
        .tmask_o       (tmask_w),
        .irq_o         (irq_o)
    );

    always_comb begin
        reg_rdata_o = '0;
        if (hit_ncause) reg_rdata_o = cause_w;
        if (hit_nmask)  reg_rdata_o = nmask_w;
        if (hit_tstat)  reg_rdata_o = status_w;
        if (hit_tmask)  reg_rdata_o = tmask_w;
    end

    // R8
    irq_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_w && tmask_w[POS_PEND]) |=> irq_o);

    // R7
    irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tmask_w == '0) |=> !irq_o);
endmodule

// File: tb/irq_hier_ctrl_test.sv
module irq_hier_ctrl_test;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] nic_evt_i = '0;
    logic [2:0] cmd_evt_i = '0;
    logic       reg_cmd_i = 1'b0;
    logic       reg_we_i = 1'b0;
    logic [7:0] reg_addr_i = '0;
    logic [7:0] reg_wdata_i = '0;
    logic [7:0] reg_rdata_o;
    logic       irq_o;

    int checks = 0;
    int fails = 0;
    bit done = 0;

    // reference model state
    logic [7:0] m_cause = '0, m_mask = '0, m_tmask = '0;
    logic       m_rst = 0, m_chal = 0, m_chres = 0, m_irq = 0;

    irq_hier_ctrl uut (
        .clk(clk), .rst_n(rst_n), .nic_evt_i(nic_evt_i), .cmd_evt_i(cmd_evt_i),
        .reg_cmd_i(reg_cmd_i), .reg_we_i(reg_we_i), .reg_addr_i(reg_addr_i),
        .reg_wdata_i(reg_wdata_i), .reg_rdata_o(reg_rdata_o), .irq_o(irq_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [7:0] m_status();
        logic [7:0] s;
        s = '0;
        s[7] = |(m_cause & m_mask);
        s[6] = m_rst;
        s[4] = m_chal;
        s[3] = m_chres;
        return s;
    endfunction

    function automatic logic [7:0] m_read(input logic cmd, input logic [7:0] a);
        if (!cmd && a == 8'h09) return m_cause;
        if (!cmd && a == 8'h08) return m_mask;
        if (cmd && a == 8'h03)  return m_status();
        if (cmd && a == 8'h02)  return m_tmask;
        return 8'h00;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cause = '0; m_mask = '0; m_tmask = '0;
            m_rst = 0; m_chal = 0; m_chres = 0; m_irq = 0;
        end else begin
            logic [7:0] cn, ct;
            m_irq = |(m_status() & m_tmask & 8'hF8);
            cn = (reg_we_i && !reg_cmd_i && reg_addr_i == 8'h09) ? reg_wdata_i : 8'h00;
            ct = (reg_we_i && reg_cmd_i && reg_addr_i == 8'h03) ? reg_wdata_i : 8'h00;
            m_cause = (m_cause & ~cn) | nic_evt_i;
            if (reg_we_i && !reg_cmd_i && reg_addr_i == 8'h08) m_mask = reg_wdata_i;
            if (reg_we_i && reg_cmd_i && reg_addr_i == 8'h02) m_tmask = reg_wdata_i;
            m_rst   = (m_rst   && !ct[6]) || cmd_evt_i[0];
            m_chal  = (m_chal  && !ct[4]) || cmd_evt_i[1];
            m_chres = (m_chres && !ct[3]) || cmd_evt_i[2];
        end
    end

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    // R8: line compared to the model on every falling edge
    always @(negedge clk) begin
        if (rst_n && !done) chk("R8 irq", {7'b0, irq_o}, {7'b0, m_irq});
    end

    task automatic drive(input logic cmd, input logic we, input logic [7:0] a,
                         input logic [7:0] d, input logic [7:0] ev, input logic [2:0] sev);
        reg_cmd_i = cmd; reg_we_i = we; reg_addr_i = a; reg_wdata_i = d;
        nic_evt_i = ev; cmd_evt_i = sev;
        @(negedge clk);
        reg_we_i = 0; nic_evt_i = '0; cmd_evt_i = '0;
    endtask

    task automatic rd(input string tag, input logic cmd, input logic [7:0] a);
        reg_cmd_i = cmd; reg_addr_i = a;
        #1;
        chk(tag, reg_rdata_o, m_read(cmd, a));
    endtask

    task automatic rd_lit(input string tag, input logic cmd, input logic [7:0] a, input logic [7:0] exp);
        reg_cmd_i = cmd; reg_addr_i = a;
        #1;
        chk(tag, reg_rdata_o, exp);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            done = 1;
            fails++; checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        idle(3);
        rst_n = 1;
        @(negedge clk);
        // R1 reset values
        rd_lit("R1 cause", 0, 8'h09, 8'h00);
        rd_lit("R1 nmask", 0, 8'h08, 8'h00);
        rd_lit("R1 status", 1, 8'h03, 8'h00);
        rd_lit("R1 tmask", 1, 8'h02, 8'h00);
        chk("R1 irq", {7'b0, irq_o}, 8'h00);

        // R2 receive event sets bit 1; masked so status bit 7 stays 0 (R5)
        drive(0, 0, 8'h00, 8'h00, 8'h02, 3'b000);
        rd_lit("R2 cause", 0, 8'h09, 8'h02);
        rd_lit("R5 masked", 1, 8'h03, 8'h00);
        idle(2);
        rd_lit("R2 hold", 0, 8'h09, 8'h02);

        // R4 mask write and readback
        drive(0, 1, 8'h08, 8'hFF, 8'h00, 3'b000);
        rd_lit("R4 nmask", 0, 8'h08, 8'hFF);
        rd_lit("R5 pend", 1, 8'h03, 8'h80);
        idle(2);

        // R7 top mask unmask upper five bits; irq follows (R8 per clock)
        drive(1, 1, 8'h02, 8'hF8, 8'h00, 3'b000);
        rd_lit("R7 tmask", 1, 8'h02, 8'hF8);
        idle(3);
        chk("R8 asserted", {7'b0, irq_o}, 8'h01);

        // R2 pattern of events, then R3 clears
        drive(0, 0, 8'h00, 8'h00, 8'hA5, 3'b000);
        rd_lit("R2 pattern", 0, 8'h09, 8'hA7);
        drive(0, 1, 8'h09, 8'h06, 8'h00, 3'b000);
        rd_lit("R3 clear", 0, 8'h09, 8'hA1);
        drive(0, 1, 8'h09, 8'h00, 8'h00, 3'b000);
        rd_lit("R3 zero write", 0, 8'h09, 8'hA1);

        // R5 partial mask: only bit 0 enabled, then cleared
        drive(0, 1, 8'h08, 8'h01, 8'h00, 3'b000);
        rd_lit("R5 partial", 1, 8'h03, 8'h80);
        drive(0, 1, 8'h09, 8'h01, 8'h00, 3'b000);
        rd_lit("R5 drop", 1, 8'h03, 8'h00);
        drive(0, 1, 8'h08, 8'hFF, 8'h00, 3'b000);
        drive(1, 1, 8'h03, 8'h80, 8'h00, 3'b000);
        rd_lit("R5 w1 bit7", 1, 8'h03, 8'h80);
        idle(2);

        // R6 command-space events and clears
        drive(1, 0, 8'h00, 8'h00, 8'h00, 3'b111);
        rd_lit("R6 set", 1, 8'h03, 8'hD8);
        drive(1, 1, 8'h03, 8'h10, 8'h00, 3'b000);
        rd_lit("R6 clr chal", 1, 8'h03, 8'hC8);
        drive(1, 1, 8'h03, 8'hFF, 8'h00, 3'b000);
        rd_lit("R6 clr all", 1, 8'h03, 8'h80);

        // R9 event and clear in the same cycle, both levels
        drive(0, 1, 8'h09, 8'hFF, 8'h10, 3'b000);
        rd_lit("R9 nic", 0, 8'h09, 8'h10);
        drive(1, 0, 8'h00, 8'h00, 8'h00, 3'b001);
        drive(1, 1, 8'h03, 8'h40, 8'h00, 3'b001);
        rd_lit("R9 top", 1, 8'h03, 8'hC0);

        // R10 unmapped addresses
        drive(0, 1, 8'h0A, 8'h5A, 8'h00, 3'b000);
        drive(1, 1, 8'h05, 8'h5A, 8'h00, 3'b000);
        rd_lit("R10 nic other", 0, 8'h0A, 8'h00);
        rd_lit("R10 cmd other", 1, 8'h05, 8'h00);
        rd("R10 cause intact", 0, 8'h09);
        rd("R10 mask intact", 0, 8'h08);
        rd("R10 tmask intact", 1, 8'h02);

        // R7 top mask only on challenge bits: pend alone must not raise irq
        drive(1, 1, 8'h03, 8'hFF, 8'h00, 3'b000);
        drive(1, 1, 8'h02, 8'h18, 8'h00, 3'b000);
        idle(3);
        chk("R7 pend masked", {7'b0, irq_o}, 8'h00);
        drive(1, 0, 8'h00, 8'h00, 8'h00, 3'b100);
        idle(2);
        chk("R8 chres irq", {7'b0, irq_o}, 8'h01);

        // R8 everything cleared, line drops
        drive(1, 1, 8'h03, 8'hFF, 8'h00, 3'b000);
        drive(0, 1, 8'h09, 8'hFF, 8'h00, 3'b000);
        idle(3);
        chk("R8 released", {7'b0, irq_o}, 8'h00);
        rd("R5 final status", 1, 8'h03);

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule